// File: doc/BRIEF.md
# Shared Memory Request Arbiter

This block sits in front of a small shared memory and serves several processing-element ports. Each port presents a single-word read or write together with a lock flag, and raises a ready line while the request waits. In every idle cycle the block looks at all ready lines at once. It picks one of them with a rotating priority, so that no port is kept waiting forever. It acknowledges the chosen port, performs the access after a fixed number of cycles, and returns a reply to that port with its own ready/acknowledge pair.

A port can claim the memory for an indivisible run of accesses by setting its lock flag. From the moment such a request is accepted, only that port can be chosen. Requests from the other ports stay pending at their inputs until the owner sends a request with the flag clear. While the lock is held the rotating pointer does not move. When the lock ends, selection restarts from the port after the one that opened the run. Only one request is in service at a time.

A requester keeps its ready line, its fields and its lock flag steady until it sees its acknowledge. After that it may drop the ready line.

Top module: `smem_arbiter`

## Requirements
- R1: While reset is asserted (`rst_n` = 0) and in the first cycle after it, `req_ack` and `rsp_rdy` are all zero.
- R2: `req_ack` has at most one bit set, and only for a port whose `req_rdy` was high in the cycle before. No new acknowledge is given while a reply is pending.
- R3: After reset the rotating pointer is at port 0. Each grant made outside a lock moves the pointer to the next higher port index, wrapping to 0. Among the ready ports, the first one found at or after the pointer is granted.
- R4: A request with `req_we` = 1 writes `req_wdata` to word `req_addr`. A request with `req_we` = 0 returns the last value written to that word on `rsp_rdata`. A write gets a reply whose data carries no meaning.
- R5: The reply is signalled on the `rsp_rdy` bit of the granted port. It rises exactly LATENCY cycles after the cycle in which that port's `req_ack` rose.
- R6: A granted request with `req_lock` = 1 starts or extends a lock held by that port. While the lock is held, no other port is acknowledged, even when it is ready.
- R7: A granted request from the owner with `req_lock` = 0 ends the lock. The pointer is frozen during the lock, so the next grant goes to the first ready port after the port that opened the run.
- R8: A lock owner that sends no request keeps the lock, and the other ready ports stay unacknowledged for as long as it is held.
- R9: `rsp_rdy` and `rsp_rdata` stay unchanged until the requester raises its `rsp_ack` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rdy | input | N_PORTS | Request ready, one bit per port |
| req_we | input | N_PORTS | 1 = write, 0 = read, per port |
| req_lock | input | N_PORTS | Indivisible-sequence flag, per port |
| req_addr | input | N_PORTS*ADDR_W | Word address, port p at bits p*ADDR_W upward |
| req_wdata | input | N_PORTS*DATA_W | Write data, port p at bits p*DATA_W upward |
| req_ack | output | N_PORTS | One-cycle request acknowledge, per port |
| rsp_rdy | output | N_PORTS | Reply ready, one-hot on the served port |
| rsp_ack | input | N_PORTS | Reply acknowledge from the requester, per port |
| rsp_rdata | output | DATA_W | Read data of the pending reply |

## Verification
A request is acknowledged one cycle after its ready line is sampled in the idle state. Its reply rises LATENCY cycles after that acknowledge. With the reply acknowledge held high, the reply lasts one cycle, and the next idle grant follows the cycle after. The bench timestamps every acknowledge against a cycle counter and checks the reply's rise at exactly that offset. A scoreboard pops one expected (port, data) item per completed reply handshake, so any grant order that departs from the pointer or lock rules shows up as a port mismatch. Lock windows and reply back-pressure are checked cycle by cycle on the falling edge, away from the edge where the design changes.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_REPLY = 2'd2
  } arb_state_e;
endpackage

// File: rtl/smem_rr_pick.sv
module smem_rr_pick #(
  parameter int N_PORTS = 4,
  localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] req,
  input  logic               adv,
  output logic               gnt_vld,
  output logic [IW-1:0]      gnt_idx
);
  logic [IW-1:0] ptr_q, ptr_d;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      int k;
      k = (int'(ptr_q) + i) % N_PORTS;
      if (!gnt_vld && req[k]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'(k);
      end
    end
  end

  always_comb begin
    if (gnt_idx == IW'(N_PORTS - 1)) ptr_d = '0;
    else                             ptr_d = gnt_idx + IW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  // R3
  pick_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> gnt_vld);
endmodule

// File: rtl/smem_lock_ctl.sv
module smem_lock_ctl #(
  parameter int N_PORTS = 4,
  localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic [IW-1:0]      gnt_idx,
  input  logic               gnt_lock,
  output logic [N_PORTS-1:0] elig,
  output logic               locked
);
  logic          act_q, act_d;
  logic [IW-1:0] own_q, own_d;

  always_comb begin
    act_d = gnt_lock;
    own_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      own_q <= '0;
    end else if (upd) begin
      act_q <= act_d;
      own_q <= own_d;
    end
  end

  always_comb begin
    if (act_q) begin
      elig = '0;
      elig[own_q] = 1'b1;
    end else begin
      elig = '1;
    end
  end

  assign locked = act_q;

  // R6
  owner_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && upd) |-> (gnt_idx == own_q));
endmodule

// File: rtl/smem_store.sv
module smem_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/smem_arbiter.sv
module smem_arbiter
  import smem_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  parameter int LATENCY = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PORTS-1:0]         req_rdy,
  input  logic [N_PORTS-1:0]         req_we,
  input  logic [N_PORTS-1:0]         req_lock,
  input  logic [N_PORTS*ADDR_W-1:0]  req_addr,
  input  logic [N_PORTS*DATA_W-1:0]  req_wdata,
  output logic [N_PORTS-1:0]         req_ack,
  output logic [N_PORTS-1:0]         rsp_rdy,
  input  logic [N_PORTS-1:0]         rsp_ack,
  output logic [DATA_W-1:0]          rsp_rdata
);
  localparam int IW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam int CW = $clog2(LATENCY + 1);

  arb_state_e          st_q, st_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic [IW-1:0]       cur_q, cur_d;
  logic                cwe_q, cwe_d;
  logic [ADDR_W-1:0]   cad_q, cad_d;
  logic [DATA_W-1:0]   cwd_q, cwd_d;
  logic [N_PORTS-1:0]  ack_q, ack_d, rrd_q, rrd_d;
  logic [DATA_W-1:0]   rdt_q, rdt_d;
  logic [N_PORTS-1:0]  elig;
  logic                locked, gnt_vld, fire, done, mem_we;
  logic [IW-1:0]       gnt_idx;
  logic [DATA_W-1:0]   mem_rd;

  assign fire = (st_q == ST_IDLE) && gnt_vld;
  assign done = (st_q == ST_BUSY) && (cnt_q == CW'(LATENCY - 1));

  smem_rr_pick #(.N_PORTS(N_PORTS)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(req_rdy & elig),
    .adv(fire && !locked), .gnt_vld(gnt_vld), .gnt_idx(gnt_idx));

  smem_lock_ctl #(.N_PORTS(N_PORTS)) u_lock (
    .clk(clk), .rst_n(rst_n), .upd(fire), .gnt_idx(gnt_idx),
    .gnt_lock(req_lock[gnt_idx]), .elig(elig), .locked(locked));

  smem_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .addr(cad_q), .wdata(cwd_q), .rdata(mem_rd));

  // next state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    ack_d  = '0;
    rrd_d  = rrd_q;
    rdt_d  = rdt_q;
    mem_we = 1'b0;
    cur_d  = gnt_idx;
    cwe_d  = req_we[gnt_idx];
    cad_d  = req_addr[gnt_idx*ADDR_W +: ADDR_W];
    cwd_d  = req_wdata[gnt_idx*DATA_W +: DATA_W];
    case (st_q)
      ST_IDLE: begin
        if (fire) begin
          st_d = ST_BUSY;
          cnt_d = '0;
          ack_d[gnt_idx] = 1'b1;
        end
      end
      ST_BUSY: begin
        cnt_d = cnt_q + CW'(1);
        if (done) begin
          st_d   = ST_REPLY;
          mem_we = cwe_q;
          rdt_d  = mem_rd;
          rrd_d  = '0;
          rrd_d[cur_q] = 1'b1;
        end
      end
      ST_REPLY: begin
        if (rsp_ack[cur_q]) begin
          st_d  = ST_IDLE;
          rrd_d = '0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ack_q <= '0;
      rrd_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ack_q <= ack_d;
      rrd_q <= rrd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      cwe_q <= 1'b0;
      cad_q <= '0;
      cwd_q <= '0;
    end else if (fire) begin
      cur_q <= cur_d;
      cwe_q <= cwe_d;
      cad_q <= cad_d;
      cwd_q <= cwd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdt_q <= '0;
    else if (done) rdt_q <= rdt_d;
  end

  assign req_ack   = ack_q;
  assign rsp_rdy   = rrd_q;
  assign rsp_rdata = rdt_q;

  // checker state, built from port activity only
  logic [7:0]         chk_lat;
  logic               chk_lk_on;
  logic [N_PORTS-1:0] chk_lk_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_lat     <= '0;
      chk_lk_on   <= 1'b0;
      chk_lk_port <= '0;
    end else if (|req_ack) begin
      chk_lat     <= 8'd1;
      chk_lk_on   <= |(req_ack & req_lock);
      chk_lk_port <= req_ack;
    end else if (chk_lat != 8'hFF) begin
      chk_lat <= chk_lat + 8'd1;
    end
  end

  // R2
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ack));
  // R2
  ack_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ack) |-> ((req_ack & ~$past(req_rdy)) == '0));
  // R2
  no_ack_in_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_rdy) |-> !(|req_ack));
  // R5
  reply_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|rsp_rdy) |-> (chk_lat == 8'(LATENCY)));
  // R6
  lock_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_lk_on && (|req_ack)) |-> (req_ack == chk_lk_port));
  // R9
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rsp_rdy) && !(|(rsp_rdy & rsp_ack))) |=>
      ((rsp_rdy == $past(rsp_rdy)) && (rsp_rdata == $past(rsp_rdata))));
endmodule

// File: tb/smem_arbiter_tb.sv
`timescale 1ns/1ps
module smem_arbiter_tb;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0]    req_rdy, req_we, req_lock, req_ack, rsp_rdy, rsp_ack;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata;
  logic [DW-1:0]   rsp_rdata;

  always #2.5 clk = ~clk;

  smem_arbiter #(.N_PORTS(N), .ADDR_W(AW), .DATA_W(DW), .LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_rdy(req_rdy), .req_we(req_we),
    .req_lock(req_lock), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack(req_ack), .rsp_rdy(rsp_rdy), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata));

  typedef struct {
    int          port;
    bit          has_data;
    logic [DW-1:0] data;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_fail = 0;
  int cyc = 0, t_ack = 0, n_acks = 0;
  bit rsp_seen = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic post(input int p, input bit we, input bit lk,
                      input int a, input int d);
    req_we[p]   = we;
    req_lock[p] = lk;
    req_addr[p*AW +: AW]  = AW'(a);
    req_wdata[p*DW +: DW] = DW'(d);
    req_rdy[p]  = 1'b1;
  endtask

  task automatic expect_rsp(input int p, input bit hd, input int d, input string tag);
    exp_t e;
    e.port = p; e.has_data = hd; e.data = DW'(d); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drain();
    while (!(sb.size() == 0 && req_rdy == '0 && rsp_rdy == '0)) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: releases acked requests, checks latency, pops the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < N; p++) begin
        if (req_ack[p]) begin
          req_rdy[p] = 1'b0;
          n_acks++;
          t_ack = cyc;
        end
      end
      if ((|rsp_rdy) && !rsp_seen) begin
        rsp_seen = 1;
        chk(cyc - t_ack == LAT, "R5", "reply delay", cyc - t_ack, LAT);
      end
      if (|(rsp_rdy & rsp_ack)) begin
        rsp_seen = 0;
        if (sb.size() == 0) begin
          chk(0, "R2", "unexpected reply on port mask", rsp_rdy, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rsp_rdy == (N'(1) << e.port), e.tag, "reply port mask",
              rsp_rdy, N'(1) << e.port);
          if (e.has_data)
            chk(rsp_rdata == e.data, "R4", "read data", rsp_rdata, e.data);
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    finish_run();
  end

  initial begin
    int n0;
    rst_n = 1'b0;
    req_rdy = '0; req_we = '0; req_lock = '0;
    req_addr = '0; req_wdata = '0; rsp_ack = '1;
    repeat (3) @(negedge clk);
    chk(req_ack == '0 && rsp_rdy == '0, "R1", "outputs in reset",
        {req_ack, rsp_rdy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ack == '0 && rsp_rdy == '0, "R1", "outputs after reset",
        {req_ack, rsp_rdy}, 0);

    // R4: single write then read from another port (pointer 0 -> 1 -> 3)
    post(0, 1, 0, 3, 16'h1111); expect_rsp(0, 0, 0, "R4");
    drain();
    post(2, 0, 0, 3, 0); expect_rsp(2, 1, 16'h1111, "R4");
    drain();

    // R3: all four ready at once, pointer at 3 -> order 3,0,1,2
    for (int p = 0; p < N; p++) post(p, 1, 0, 4 + p, 16'hA0 + p);
    expect_rsp(3, 0, 0, "R3"); expect_rsp(0, 0, 0, "R3");
    expect_rsp(1, 0, 0, "R3"); expect_rsp(2, 0, 0, "R3");
    drain();
    for (int p = 0; p < N; p++) post(p, 0, 0, 4 + p, 0);
    expect_rsp(3, 1, 16'hA3, "R3"); expect_rsp(0, 1, 16'hA0, "R3");
    expect_rsp(1, 1, 16'hA1, "R3"); expect_rsp(2, 1, 16'hA2, "R3");
    drain();

    // R6: port 1 opens a lock while pointer is at 3
    post(1, 1, 1, 8, 16'h0B01); expect_rsp(1, 0, 0, "R6");
    while (req_rdy[1]) @(negedge clk);
    @(negedge clk);
    post(0, 1, 0, 12, 16'hC0);
    post(2, 1, 0, 14, 16'hC2);
    post(3, 1, 0, 15, 16'hC3);
    post(1, 0, 1, 8, 0); expect_rsp(1, 1, 16'h0B01, "R6");
    while (!(sb.size() == 0 && !req_rdy[1] && rsp_rdy == '0)) @(negedge clk);

    // R8: owner idle, lock held, others must wait
    n0 = n_acks;
    repeat (12) @(negedge clk);
    chk(n_acks == n0, "R8", "acks while lock idle", n_acks - n0, 0);
    chk(req_rdy == 4'b1101, "R6", "others still pending", req_rdy, 4'b1101);

    // R7: owner closes the lock; pointer frozen at 2 -> order 2,3,0
    post(1, 1, 0, 8, 16'h0B02);
    expect_rsp(1, 0, 0, "R7"); expect_rsp(2, 0, 0, "R7");
    expect_rsp(3, 0, 0, "R7"); expect_rsp(0, 0, 0, "R7");
    drain();
    post(3, 0, 0, 8, 0); expect_rsp(3, 1, 16'h0B02, "R7");
    drain();
    post(2, 0, 0, 14, 0); expect_rsp(2, 1, 16'hC2, "R4");
    drain();

    // R9: reply held while port 0 withholds its acknowledge
    rsp_ack[0] = 1'b0;
    post(0, 0, 0, 4, 0); expect_rsp(0, 1, 16'hA0, "R9");
    while (!rsp_rdy[0]) @(negedge clk);
    post(2, 0, 0, 5, 0); expect_rsp(2, 1, 16'hA1, "R2");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(rsp_rdy == 4'b0001 && rsp_rdata == 16'hA0, "R9", "held reply",
          {rsp_rdy, rsp_rdata}, {4'b0001, 16'hA0});
      chk(req_ack == '0, "R2", "ack while reply pending", req_ack, 0);
    end
    rsp_ack[0] = 1'b1;
    drain();

    finish_run();
  end
endmodule